// File: doc/BRIEF.md
# Low-Power Mode Clock-Gating Controller

This block turns the four power-control bits of a processor status word into registered enables for five clock resources. The resources are the CPU clock, the subsystem clock, the auxiliary clock, the digitally controlled oscillator (DCO) and the DC generator that biases the DCO. Software enters a low-power mode by writing the power bits. The block then gates the matching resources and keeps them gated until an interrupt is accepted.

When an interrupt is accepted, the block copies the current power bits into a one-level save register. It then clears every power bit except generator bit 0, which wakes the CPU. A return-from-interrupt strobe copies the save register back into the power bits. This brings back the mode that was active before the interrupt. A handler may overwrite the saved copy, and the overwritten value is the one restored on return. A peripheral can ask for the DCO. That request keeps the DC generator running while generator bit 0 is set, as long as the oscillator-off bit is clear.

Power-bit encoding used throughout: bit 0 is CPU off, bit 1 is oscillator off, bit 2 is generator bit 0, bit 3 is generator bit 1. The five modes are written as 4-bit values: LPM0 = 0001, LPM1 = 0101, LPM2 = 1001, LPM3 = 1101 and LPM4 = 1111.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: While reset is asserted, and once it is released, the power bits read 0000 and all five clock enables are 1.
- R2: With power bits 0000 (active mode), all five enables are 1.
- R3: In LPM0 (0001), the CPU clock enable is 0 and the subsystem, auxiliary, DCO and DC-generator enables are 1.
- R4: In LPM1 (0101), the enables match LPM0 except the DC-generator enable. That enable is 0 when no DCO request is present and 1 while the request is present.
- R5: In LPM2 (1001), the CPU clock, subsystem clock and DCO enables are 0, and the auxiliary clock and DC-generator enables are 1.
- R6: In LPM3 (1101), only the auxiliary clock enable is 1. A DCO request also turns on the DC-generator enable.
- R7: In LPM4 (1111), all five enables are 0, even while a DCO request is present.
- R8: An accepted interrupt saves the power bits and clears bits 0, 1 and 3 while keeping bit 2. The power bits change at the next clock edge, and the CPU clock enable is 1 no later than the second edge after the accept strobe.
- R9: A return strobe loads the save register into the power bits at the next edge. This restores the mode that was active before the interrupt.
- R10: A write to the save register while the handler runs changes the mode that the next return restores.
- R11: An interrupt accept takes priority over a software write of the power bits in the same cycle. It also takes priority over a return and over a save-register write in that cycle.
- R12: The enables are registered. They follow the power bits one clock edge later and never change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srWrEn | input | 1 | Software write strobe for the power bits |
| srWrData | input | 4 | Power bits to write |
| dcoRequest | input | 1 | Peripheral request to keep the DCO DC generator on |
| irqAccept | input | 1 | Interrupt accepted strobe |
| irqReturn | input | 1 | Return-from-interrupt strobe |
| saveWrEn | input | 1 | Handler write strobe for the saved power bits |
| saveWrData | input | 4 | New saved power bits |
| powerState | output | 4 | Current power bits |
| cpuClkEn | output | 1 | CPU clock enable |
| smclkEn | output | 1 | Subsystem clock enable |
| aclkEn | output | 1 | Auxiliary clock enable |
| dcoEn | output | 1 | DCO enable |
| dcGenEn | output | 1 | DCO DC-generator enable |

## Verification
The assertions check every cycle for the following:
- the mode decodes that can be stated from the previous cycle's power bits (active, LPM3, LPM4);
- the partial clearing on interrupt accept;
- the restore on return;
- the two-edge CPU wake-up;
- that at most one strobe wins arbitration in any cycle.

Only the bench scenarios show full round trips through a handler: entering a mode, waking, optionally rewriting the saved copy, and returning. They also show how the DCO request interacts with each mode, and the one-cycle gap during which the power bits have changed but the enables have not.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  localparam int PWR_W = 4;

  typedef struct packed {
    logic scg1;
    logic scg0;
    logic oscOff;
    logic cpuOff;
  } pwr_t;

  typedef struct packed {
    logic wake;
    logic restore;
    logic swLoad;
    logic saveWrite;
  } strobe_t;

  typedef struct packed {
    logic cpu;
    logic smclk;
    logic aclk;
    logic dco;
    logic dcGen;
  } clk_en_t;

  localparam pwr_t PWR_ACTIVE = '{scg1: 1'b0, scg0: 1'b0, oscOff: 1'b0, cpuOff: 1'b0};
  localparam clk_en_t EN_ALL_ON = '{cpu: 1'b1, smclk: 1'b1, aclk: 1'b1, dco: 1'b1, dcGen: 1'b1};

endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    srWrEn,
  input  logic    irqAccept,
  input  logic    irqReturn,
  input  logic    saveWrEn,
  output strobe_t strobes
);

  // Arbitration: wake beats everything, restore beats a software write.
  always_comb begin
    strobes.wake      = irqAccept;
    strobes.restore   = irqReturn & ~irqAccept;
    strobes.swLoad    = srWrEn & ~irqAccept & ~irqReturn;
    strobes.saveWrite = saveWrEn & ~irqAccept;
  end

  // R11: only one of the power-bit sources may win in any cycle
  p_single_source_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wake, strobes.restore, strobes.swLoad}));

  // R11: an accept is never masked by a simultaneous write
  p_accept_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqAccept |-> (strobes.wake && !strobes.swLoad && !strobes.saveWrite));

endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int PWR_BITS = PWR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobes,
  input  logic [PWR_BITS-1:0] srWrData,
  input  logic [PWR_BITS-1:0] saveWrData,
  input  logic                dcoRequest,
  output pwr_t                powerReg,
  output clk_en_t             enReg
);

  pwr_t    saveReg;
  pwr_t    powerNext;
  pwr_t    saveNext;
  clk_en_t enNext;

  // Next power bits and saved copy
  always_comb begin
    powerNext = powerReg;
    saveNext  = saveReg;
    if (strobes.wake) begin
      saveNext         = powerReg;
      powerNext.cpuOff = 1'b0;
      powerNext.oscOff = 1'b0;
      powerNext.scg1   = 1'b0;
    end else begin
      if (strobes.restore)   powerNext = saveReg;
      if (strobes.swLoad)    powerNext = pwr_t'(srWrData);
      if (strobes.saveWrite) saveNext  = pwr_t'(saveWrData);
    end
  end

  // Mode decode into clock enables
  always_comb begin
    enNext.cpu   = ~powerReg.cpuOff;
    enNext.aclk  = ~powerReg.oscOff;
    enNext.smclk = ~powerReg.scg1;
    enNext.dco   = ~powerReg.scg1;
    enNext.dcGen = ~powerReg.scg0 | (dcoRequest & ~powerReg.oscOff);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      powerReg <= PWR_ACTIVE;
      saveReg  <= PWR_ACTIVE;
      enReg    <= EN_ALL_ON;
    end else begin
      powerReg <= powerNext;
      saveReg  <= saveNext;
      enReg    <= enNext;
    end
  end

  // R2: active mode leads to every enable on at the next edge
  p_active_all_on_r2: assert property (@(posedge clk) disable iff (!rstN)
    (powerReg == PWR_ACTIVE) |=> (enReg == EN_ALL_ON));

  // R6: LPM3 keeps only the auxiliary clock (plus a requested generator)
  p_lpm3_aux_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (powerReg == pwr_t'(4'b1101)) |=>
      (enReg.aclk && !enReg.cpu && !enReg.smclk && !enReg.dco && (enReg.dcGen == $past(dcoRequest))));

  // R7: LPM4 stops everything
  p_lpm4_all_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (powerReg == pwr_t'(4'b1111)) |=> (enReg == '0));

  // R8: accept clears CPU-off, oscillator-off and generator bit 1, keeps generator bit 0
  p_wake_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wake |=> (!powerReg.cpuOff && !powerReg.oscOff && !powerReg.scg1 &&
                      powerReg.scg0 == $past(powerReg.scg0)));

  // R8: CPU clock back within two edges
  p_cpu_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wake |=> ##1 enReg.cpu);

  // R9: return restores the saved copy when it is not rewritten that cycle
  p_restore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.restore && !strobes.saveWrite) |=> (powerReg == $past(saveReg)));

  // R12: the CPU enable only moves one edge after the CPU-off bit
  p_cpu_en_lag_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(enReg.cpu) |-> (enReg.cpu == !$past(powerReg.cpuOff)));

endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       srWrEn,
  input  logic [3:0] srWrData,
  input  logic       dcoRequest,
  input  logic       irqAccept,
  input  logic       irqReturn,
  input  logic       saveWrEn,
  input  logic [3:0] saveWrData,
  output logic [3:0] powerState,
  output logic       cpuClkEn,
  output logic       smclkEn,
  output logic       aclkEn,
  output logic       dcoEn,
  output logic       dcGenEn
);

  strobe_t strobes;
  pwr_t    powerReg;
  clk_en_t enReg;

  lpm_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .srWrEn    (srWrEn),
    .irqAccept (irqAccept),
    .irqReturn (irqReturn),
    .saveWrEn  (saveWrEn),
    .strobes   (strobes)
  );

  lpm_datapath #(.PWR_BITS(PWR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .srWrData   (srWrData),
    .saveWrData (saveWrData),
    .dcoRequest (dcoRequest),
    .powerReg   (powerReg),
    .enReg      (enReg)
  );

  assign powerState = powerReg;
  assign cpuClkEn   = enReg.cpu;
  assign smclkEn    = enReg.smclk;
  assign aclkEn     = enReg.aclk;
  assign dcoEn      = enReg.dco;
  assign dcGenEn    = enReg.dcGen;

endmodule

// File: tb/lpm_clock_ctrl_bench.sv
module lpm_clock_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       srWrEn, dcoRequest, irqAccept, irqReturn, saveWrEn;
  logic [3:0] srWrData, saveWrData;
  logic [3:0] powerState;
  logic       cpuClkEn, smclkEn, aclkEn, dcoEn, dcGenEn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lpm_clock_ctrl u_lpm_clock_ctrl (
    .clk(clk), .rstN(rstN), .srWrEn(srWrEn), .srWrData(srWrData),
    .dcoRequest(dcoRequest), .irqAccept(irqAccept), .irqReturn(irqReturn),
    .saveWrEn(saveWrEn), .saveWrData(saveWrData), .powerState(powerState),
    .cpuClkEn(cpuClkEn), .smclkEn(smclkEn), .aclkEn(aclkEn),
    .dcoEn(dcoEn), .dcGenEn(dcGenEn)
  );

  // enable order: {cpu, smclk, aclk, dco, dcGen}
  task automatic checkEn(string req, logic [4:0] expv);
    logic [4:0] act;
    act = {cpuClkEn, smclkEn, aclkEn, dcoEn, dcGenEn};
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s enables actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic checkPwr(string req, logic [3:0] expv);
    checks++;
    if (powerState !== expv) begin
      failures++;
      $display("FAIL %s power actual=%b expected=%b", req, powerState, expv);
    end
  endtask

  // write power bits, then wait until the enables have followed
  task automatic writePower(logic [3:0] v);
    @(negedge clk); srWrEn = 1'b1; srWrData = v;
    @(negedge clk); srWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseAccept();
    @(negedge clk); irqAccept = 1'b1;
    @(negedge clk); irqAccept = 1'b0;
  endtask

  task automatic pulseReturn();
    @(negedge clk); irqReturn = 1'b1;
    @(negedge clk); irqReturn = 1'b0;
  endtask

  task automatic testReset();
    checkPwr("R1", 4'b0000);
    checkEn("R1", 5'b11111);
  endtask

  task automatic testModes();
    writePower(4'b0000); checkEn("R2", 5'b11111);
    writePower(4'b0001); checkEn("R3", 5'b01111);
    writePower(4'b0101); checkEn("R4", 5'b01110);
    dcoRequest = 1'b1; @(negedge clk);
    checkEn("R4", 5'b01111);
    dcoRequest = 1'b0; @(negedge clk);
    writePower(4'b1001); checkEn("R5", 5'b00101);
    writePower(4'b1101); checkEn("R6", 5'b00100);
    dcoRequest = 1'b1; @(negedge clk);
    checkEn("R6", 5'b00101);
    dcoRequest = 1'b0; @(negedge clk);
    writePower(4'b1111); checkEn("R7", 5'b00000);
    dcoRequest = 1'b1; @(negedge clk); @(negedge clk);
    checkEn("R7", 5'b00000);
    dcoRequest = 1'b0;
  endtask

  task automatic testWakeReturn();
    writePower(4'b1101);
    pulseAccept();
    checkPwr("R8", 4'b0100);
    @(negedge clk);
    checkEn("R8", 5'b11110);
    pulseReturn();
    checkPwr("R9", 4'b1101);
    @(negedge clk);
    checkEn("R9", 5'b00100);
  endtask

  task automatic testModifiedSave();
    writePower(4'b1111);
    pulseAccept();
    checkPwr("R8", 4'b0100);
    @(negedge clk); saveWrEn = 1'b1; saveWrData = 4'b0001;
    @(negedge clk); saveWrEn = 1'b0;
    pulseReturn();
    checkPwr("R10", 4'b0001);
    @(negedge clk);
    checkEn("R10", 5'b01111);
  endtask

  task automatic testPriority();
    writePower(4'b1001);
    @(negedge clk); irqAccept = 1'b1; srWrEn = 1'b1; srWrData = 4'b1111;
    @(negedge clk); irqAccept = 1'b0; srWrEn = 1'b0;
    checkPwr("R11", 4'b0000);
    pulseReturn();
    checkPwr("R11", 4'b1001);
    @(negedge clk);
  endtask

  task automatic testRegistered();
    writePower(4'b0000);
    @(negedge clk); srWrEn = 1'b1; srWrData = 4'b1111;
    @(negedge clk); srWrEn = 1'b0;
    checkPwr("R12", 4'b1111);
    checkEn("R12", 5'b11111);
    @(negedge clk);
    checkEn("R12", 5'b00000);
  endtask

  initial begin
    rstN = 1'b0; srWrEn = 0; srWrData = '0; dcoRequest = 0;
    irqAccept = 0; irqReturn = 0; saveWrEn = 0; saveWrData = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testModes();
    testWakeReturn();
    testModifiedSave();
    testPriority();
    testRegistered();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule